// File: doc/BRIEF.md
# Interrupt Entry and Vector Sequencer

This block owns the program counter of a small 8-bit-style core. On every instruction boundary it picks the next PC from four sources: the next word, the word after next (for two-word instructions), a branch target, or the address of a slot in an interrupt jump table. It also tracks which interrupt sources have requested service and chooses one to take. On entry it clears the global interrupt-enable flag and saves the return PC on a byte-wide stack. A return-from-interrupt command restores the PC from that stack and sets the enable flag again.

The core's decoder reports each completed instruction on `instr_done`. With that strobe it reports whether the instruction was two words long, whether a branch was taken and to where, and whether it was a return-from-interrupt. The jump table starts at word 0x0000. Each slot is two words wide and sources are numbered from 1, so source k enters at word address 2*(k-1). While the sequencer drives the stack it holds `seq_busy` high and the core stalls. The stack memory is byte wide and answers a read one cycle after the request.

Top module: `irq_vector_seq`

## Requirements
- R1: While reset is asserted and on release, `pc` is 0x0000, `irq_enable` is 0, no request is pending, `irq_ack` is zero, `seq_busy` is 0 and `stk_ptr` equals the STACK_TOP parameter.
- R2: When no interrupt is taken, a cycle with `instr_done` high and `branch_taken` low loads `pc` with `pc`+1, or with `pc`+2 when `instr_two_word` is high. The sum wraps at 16 bits.
- R3: A cycle with `instr_done` high and `branch_taken` high loads `pc` with `branch_target`, whatever `instr_two_word` is.
- R4: A cycle in the run state with `instr_done` low leaves `pc` unchanged.
- R5: An interrupt is taken on a cycle with `instr_done` high, `reti_cmd` low, `irq_enable` high and at least one pending source. The lowest-numbered pending source wins. Source k is bit k-1 of `irq_req` and `irq_ack`. On the next cycle `pc` is 2*(k-1) (source 12 gives 0x0016), `irq_enable` is 0, and `irq_ack` holds only bit k-1 for exactly one cycle. That source's pending bit is then clear.
- R6: In the two cycles after an interrupt is taken, the block writes the return PC to the stack. The low byte goes to address `stk_ptr`, then the high byte goes to `stk_ptr`-1. The pointer decrements after each write, so it ends 2 lower. `stk_re` stays low during both writes.
- R7: A cycle with `instr_done` and `reti_cmd` high starts a pop. The block reads `stk_ptr`+1 (the high byte) and then the next address up (the low byte), incrementing the pointer before each read. Three cycles after the command `pc` holds the restored value and `irq_enable` is 1.
- R8: A request made while `irq_enable` is low stays pending. It is taken on the first `instr_done` after the flag has been set.
- R9: `irq_enable` is set only by the completion of a return sequence. No `irq_ack` is raised while the flag is low.
- R10: While `seq_busy` is high, `instr_done` and the other instruction inputs are ignored and `pc` does not change, except on the final pop cycle when the restored value loads.
- R11: The return PC that is pushed is the value `pc` would have taken without the interrupt: the branch target, `pc`+2 or `pc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | The current instruction completes this cycle |
| instr_two_word | input | 1 | The completing instruction occupies two words |
| branch_taken | input | 1 | The completing instruction redirects flow |
| branch_target | input | 16 | Word address of the redirect |
| reti_cmd | input | 1 | The completing instruction is a return-from-interrupt |
| irq_req | input | 35 | One-cycle request pulses, bit k-1 for source k |
| irq_ack | output | 35 | One-hot acknowledge of the source taken |
| pc | output | 16 | Current program counter (word address) |
| irq_enable | output | 1 | Global interrupt-enable flag |
| seq_busy | output | 1 | Stack sequence in progress; the core must stall |
| stk_addr | output | 16 | Stack memory byte address |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe; data returns next cycle |
| stk_wdata | output | 8 | Stack write byte |
| stk_rdata | input | 8 | Stack read byte, one cycle after `stk_re` |
| stk_ptr | output | 16 | Stack pointer |

## Verification
Flow changes of R2 to R4 show on `pc` one edge after the strobe. An interrupt taken at one edge shows its vector, its cleared flag and its acknowledge together on the next cycle, followed by one stack write per cycle for two cycles. A return shows two read cycles and then the restored PC and the set flag on the third cycle after the command. The bench keeps a cycle-level model advanced by bench functions at each falling edge, using the inputs it has just driven. It compares every output, including the combinational stack strobes, at the next falling edge, which is where each result is due. Directed sequences add explicit checks at those same edges.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    SQ_RUN,
    SQ_PUSH_LO,
    SQ_PUSH_HI,
    SQ_POP_HI,
    SQ_POP_LO,
    SQ_POP_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    NX_INC1,
    NX_INC2,
    NX_BRANCH,
    NX_VECTOR
  } nxt_sel_e;

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int NUM_SRC = 35,
  parameter int PC_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               take,
  output logic               any_pend,
  output logic [PC_W-1:0]    vec_addr,
  output logic [NUM_SRC-1:0] ack
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   grant_idx;

  // table slots are two words wide: index i (source i+1) enters at 2*i
  function automatic logic [PC_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    return PC_W'({idx, 1'b0});
  endfunction

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
      end
    end
  end

  assign any_pend = |pend_q;
  assign vec_addr = slot_addr(grant_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ack    <= '0;
    end else begin
      pend_q <= (pend_q & ~(take ? grant : '0)) | req;
      ack    <= take ? grant : '0;
    end
  end

  // R5: acknowledge is a single source, and it was the lowest pending one
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> ((($past(pend_q) & ack) != '0) &&
                (($past(pend_q) & (ack - 1'b1)) == '0)));
  // R5: a taken source's pending bit is gone unless re-requested
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> (((pend_q & ack) == '0) || (($past(req) & ack) != '0)));

endmodule

// File: rtl/irq_stack_port.sv
module irq_stack_port #(
  parameter int              SP_W      = 16,
  parameter logic [SP_W-1:0] STACK_TOP = 16'h00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [7:0]      wbyte,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] addr,
  output logic            we,
  output logic            re,
  output logic [7:0]      wdata
);
  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  // push writes at sp then decrements; pop increments and reads there
  function automatic logic [SP_W-1:0] access_addr(input logic [SP_W-1:0] p,
                                                  input logic is_pop);
    return is_pop ? p + ONE : p;
  endfunction

  assign addr  = access_addr(sp, pop);
  assign we    = push;
  assign re    = pop;
  assign wdata = wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= STACK_TOP;
    else if (push) sp <= sp - ONE;
    else if (pop)  sp <= sp + ONE;
  end

  p_push_pop_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  p_sp_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == $past(sp) - ONE));
  p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (sp == $past(sp) + ONE));

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import irq_seq_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  nxt_sel_e        sel,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] vec,
  output logic [PC_W-1:0] nxt
);
  function automatic logic [PC_W-1:0] advance(input logic [PC_W-1:0] p,
                                              input logic two);
    return p + (two ? PC_W'(2) : PC_W'(1));
  endfunction

  always_comb begin
    unique case (sel)
      NX_INC1:   nxt = advance(pc, 1'b0);
      NX_INC2:   nxt = advance(pc, 1'b1);
      NX_BRANCH: nxt = target;
      NX_VECTOR: nxt = vec;
      default:   nxt = advance(pc, 1'b0);
    endcase
  end

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_seq_pkg::*;
#(
  parameter int              NUM_SRC   = 35,
  parameter int              PC_W      = 16,
  parameter int              SP_W      = 16,
  parameter logic [SP_W-1:0] STACK_TOP = 16'h00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done,
  input  logic               instr_two_word,
  input  logic               branch_taken,
  input  logic [PC_W-1:0]    branch_target,
  input  logic               reti_cmd,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [NUM_SRC-1:0] irq_ack,
  output logic [PC_W-1:0]    pc,
  output logic               irq_enable,
  output logic               seq_busy,
  output logic [SP_W-1:0]    stk_addr,
  output logic               stk_we,
  output logic               stk_re,
  output logic [7:0]         stk_wdata,
  input  logic [7:0]         stk_rdata,
  output logic [SP_W-1:0]    stk_ptr
);
  seq_state_e      state_q;
  logic            any_pend;
  logic [PC_W-1:0] vec_addr;
  logic [PC_W-1:0] flow_pc;
  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] ret_q;
  logic [7:0]      hi_q;
  nxt_sel_e        flow_sel;
  nxt_sel_e        next_sel;

  // named events for assertions
  logic at_boundary;
  logic take_irq;
  logic start_ret;
  logic do_push;
  logic do_pop;

  assign at_boundary = (state_q == SQ_RUN) && instr_done;
  assign start_ret   = at_boundary && reti_cmd;
  assign take_irq    = at_boundary && !reti_cmd && irq_enable && any_pend;
  assign do_push     = (state_q == SQ_PUSH_LO) || (state_q == SQ_PUSH_HI);
  assign do_pop      = (state_q == SQ_POP_HI) || (state_q == SQ_POP_LO);
  assign seq_busy    = (state_q != SQ_RUN);

  function automatic logic [PC_W-1:0] join_bytes(input logic [7:0] hi,
                                                 input logic [7:0] lo);
    return PC_W'({hi, lo});
  endfunction

  function automatic logic [PC_W-1:0] ack_slot(input logic [NUM_SRC-1:0] a);
    logic [PC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++) if (a[i]) r = PC_W'(2 * i);
    return r;
  endfunction

  always_comb begin
    if (branch_taken)        flow_sel = NX_BRANCH;
    else if (instr_two_word) flow_sel = NX_INC2;
    else                     flow_sel = NX_INC1;
    next_sel = take_irq ? NX_VECTOR : flow_sel;
  end

  irq_pend_arb #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .take     (take_irq),
    .any_pend (any_pend),
    .vec_addr (vec_addr),
    .ack      (irq_ack)
  );

  pc_next_mux #(.PC_W(PC_W)) u_flow_mux (
    .sel    (flow_sel),
    .pc     (pc),
    .target (branch_target),
    .vec    (vec_addr),
    .nxt    (flow_pc)
  );

  pc_next_mux #(.PC_W(PC_W)) u_next_mux (
    .sel    (next_sel),
    .pc     (pc),
    .target (branch_target),
    .vec    (vec_addr),
    .nxt    (next_pc)
  );

  irq_stack_port #(.SP_W(SP_W), .STACK_TOP(STACK_TOP)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_push),
    .pop   (do_pop),
    .wbyte ((state_q == SQ_PUSH_LO) ? ret_q[7:0] : 8'(ret_q >> 8)),
    .sp    (stk_ptr),
    .addr  (stk_addr),
    .we    (stk_we),
    .re    (stk_re),
    .wdata (stk_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_RUN;
      pc         <= '0;
      irq_enable <= 1'b0;
      ret_q      <= '0;
      hi_q       <= '0;
    end else begin
      unique case (state_q)
        SQ_RUN: begin
          if (start_ret) begin
            state_q <= SQ_POP_HI;
          end else if (take_irq) begin
            ret_q      <= flow_pc;
            pc         <= next_pc;
            irq_enable <= 1'b0;
            state_q    <= SQ_PUSH_LO;
          end else if (at_boundary) begin
            pc <= next_pc;
          end
        end
        SQ_PUSH_LO: state_q <= SQ_PUSH_HI;
        SQ_PUSH_HI: state_q <= SQ_RUN;
        SQ_POP_HI:  state_q <= SQ_POP_LO;
        SQ_POP_LO: begin
          hi_q    <= stk_rdata;
          state_q <= SQ_POP_FIN;
        end
        SQ_POP_FIN: begin
          pc         <= join_bytes(hi_q, stk_rdata);
          irq_enable <= 1'b1;
          state_q    <= SQ_RUN;
        end
        default: state_q <= SQ_RUN;
      endcase
    end
  end

  // R5: the acknowledge arrives with the flag already cleared and pc on its slot
  p_ie_clear_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> !irq_enable);
  p_vector_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (pc == ack_slot(irq_ack)));
  // R9: only a masked-on flag lets an acknowledge out; only a pop sets it
  p_no_ack_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> $past(irq_enable));
  p_ie_set_by_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_enable) |-> $past(state_q == SQ_POP_FIN));
  // R10: pc frozen across the stack cycles that precede the restore
  p_pc_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push || do_pop) |=> $stable(pc));
  // R6: the push pair follows an entry back-to-back
  p_push_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PUSH_LO) |=> (stk_we && (state_q == SQ_PUSH_HI)));

endmodule

// File: tb/irq_vector_seq_tb.sv
module irq_vector_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 35;
  localparam logic [15:0] TOP = 16'h00F0;

  logic        clk;
  logic        rst_n;
  logic        instr_done, instr_two_word, branch_taken, reti_cmd;
  logic [15:0] branch_target;
  logic [NSRC-1:0] irq_req, irq_ack;
  logic [15:0] pc, stk_addr, stk_ptr;
  logic        irq_enable, seq_busy, stk_we, stk_re;
  logic [7:0]  stk_wdata, stk_rdata;

  irq_vector_seq #(.NUM_SRC(NSRC), .PC_W(16), .SP_W(16), .STACK_TOP(TOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .instr_two_word(instr_two_word),
    .branch_taken(branch_taken), .branch_target(branch_target), .reti_cmd(reti_cmd),
    .irq_req(irq_req), .irq_ack(irq_ack), .pc(pc), .irq_enable(irq_enable),
    .seq_busy(seq_busy), .stk_addr(stk_addr), .stk_we(stk_we), .stk_re(stk_re),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .stk_ptr(stk_ptr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // stack memory environment, one-cycle read latency
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr[7:0]] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr[7:0]];
  end

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [15:0] m_pc, m_sp, m_ret;
  logic        m_ie;
  logic [NSRC-1:0] m_pend, m_ack;
  int          m_phase;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flow(input logic [15:0] p, input logic two,
                                           input logic br, input logic [15:0] tg);
    return br ? tg : p + (two ? 16'd2 : 16'd1);
  endfunction

  function automatic int lowest_src(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic lockstep_check();
    check("R2 pc", 64'(pc), 64'(m_pc));
    check("R9 irq_enable", 64'(irq_enable), 64'(m_ie));
    check("R6 stk_ptr", 64'(stk_ptr), 64'(m_sp));
    check("R10 seq_busy", 64'(seq_busy), 64'(m_phase != 0));
    check("R5 irq_ack", 64'(irq_ack), 64'(m_ack));
    if (m_phase == 1 || m_phase == 2) begin
      check("R6 stk_we", 64'(stk_we), 64'd1);
      check("R6 stk_addr", 64'(stk_addr), 64'(m_sp));
      check("R11 stk_wdata", 64'(stk_wdata),
            64'((m_phase == 1) ? m_ret[7:0] : m_ret[15:8]));
    end else if (m_phase == 3 || m_phase == 4) begin
      check("R7 stk_re", 64'(stk_re), 64'd1);
      check("R7 stk_addr", 64'(stk_addr), 64'(m_sp + 16'd1));
    end else begin
      check("R6 no stack access", 64'({stk_we, stk_re}), 64'd0);
    end
  endtask

  task automatic model_step(input logic s, input logic tw, input logic br,
                            input logic [15:0] tg, input logic rt,
                            input logic [NSRC-1:0] rq);
    logic [NSRC-1:0] nack;
    int k;
    nack = '0;
    case (m_phase)
      0: if (s) begin
        if (rt) m_phase = 3;
        else if (m_ie && (|m_pend)) begin
          k = lowest_src(m_pend);
          nack[k] = 1'b1;
          m_pend[k] = 1'b0;
          m_ie = 1'b0;
          m_ret = exp_flow(m_pc, tw, br, tg);
          m_pc = 16'(2 * k);
          m_phase = 1;
        end else m_pc = exp_flow(m_pc, tw, br, tg);
      end
      1: begin m_sp = m_sp - 16'd1; m_phase = 2; end
      2: begin m_sp = m_sp - 16'd1; m_phase = 0; end
      3: begin m_sp = m_sp + 16'd1; m_phase = 4; end
      4: begin m_sp = m_sp + 16'd1; m_phase = 5; end
      default: begin
        m_pc = {mem[8'(m_sp - 16'd1)], mem[m_sp[7:0]]};
        m_ie = 1'b1;
        m_phase = 0;
      end
    endcase
    m_pend = m_pend | rq;
    m_ack = nack;
  endtask

  task automatic cycle(input logic s, input logic tw, input logic br,
                       input logic [15:0] tg, input logic rt, input logic [NSRC-1:0] rq);
    lockstep_check();
    instr_done = s; instr_two_word = tw; branch_taken = br;
    branch_target = tg; reti_cmd = rt; irq_req = rq;
    model_step(s, tw, br, tg, rt, rq);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[8'hF1] = 8'h12;
    mem[8'hF2] = 8'h40;
    stk_rdata = 8'h00;
    rst_n = 1'b0;
    instr_done = 0; instr_two_word = 0; branch_taken = 0; reti_cmd = 0;
    branch_target = '0; irq_req = '0;
    m_pc = '0; m_sp = TOP; m_ret = '0; m_ie = 0; m_pend = '0; m_ack = '0; m_phase = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", 64'(pc), 64'h0);
    check("R1 irq_enable", 64'(irq_enable), 64'h0);
    check("R1 stk_ptr", 64'(stk_ptr), 64'(TOP));
    check("R1 busy/ack", 64'({seq_busy, irq_ack}), 64'h0);
    rst_n = 1'b1;

    cycle(1, 0, 0, 16'h0, 0, '0);
    check("R2 +1", 64'(pc), 64'h1);
    cycle(1, 1, 0, 16'h0, 0, '0);
    check("R2 +2", 64'(pc), 64'h3);
    cycle(1, 1, 1, 16'h1234, 0, '0);
    check("R3 branch", 64'(pc), 64'h1234);
    cycle(0, 1, 1, 16'h5555, 0, '0);
    check("R4 hold", 64'(pc), 64'h1234);

    // source 12 while masked
    cycle(1, 0, 0, 16'h0, 0, NSRC'(1) << 11);
    cycle(1, 0, 0, 16'h0, 0, '0);
    check("R9 masked no ack", 64'(irq_ack), 64'h0);
    check("R9 masked pc", 64'(pc), 64'h1236);

    // return: pops 0x12 then 0x40; stall inputs ignored meanwhile
    cycle(1, 0, 0, 16'h0, 1, '0);
    cycle(1, 0, 1, 16'h7777, 0, '0);
    check("R10 pc frozen", 64'(pc), 64'h1236);
    cycle(1, 0, 1, 16'h7777, 0, '0);
    cycle(1, 0, 1, 16'h7777, 0, '0);
    check("R7 restored pc", 64'(pc), 64'h1240);
    check("R7 ie set", 64'(irq_enable), 64'h1);
    check("R7 sp back", 64'(stk_ptr), 64'(TOP + 16'd2));

    // R8: pending source 12 taken on first boundary after enable
    cycle(1, 1, 0, 16'h0, 0, '0);
    check("R8 vector src12", 64'(pc), 64'h0016);
    check("R5 ack src12", 64'(irq_ack), 64'(NSRC'(1) << 11));
    check("R5 ie cleared", 64'(irq_enable), 64'h0);
    check("R11 ret low byte", 64'({stk_we, stk_addr, stk_wdata}),
          64'({1'b1, TOP + 16'd2, 8'h42}));
    cycle(0, 0, 0, 16'h0, 0, '0);
    check("R11 ret high byte", 64'({stk_we, stk_addr, stk_wdata}),
          64'({1'b1, TOP + 16'd1, 8'h12}));
    cycle(0, 0, 0, 16'h0, 0, '0);
    check("R6 sp after push", 64'(stk_ptr), 64'(TOP));

    // R5 lowest wins: sources 3 and 20 together
    cycle(0, 0, 0, 16'h0, 0, (NSRC'(1) << 2) | (NSRC'(1) << 19));
    cycle(1, 0, 0, 16'h0, 1, '0);
    repeat (3) cycle(0, 0, 0, 16'h0, 0, '0);
    check("R7 pc from stack", 64'(pc), 64'h1242);
    cycle(1, 0, 0, 16'h0, 0, '0);
    check("R5 lowest src3", 64'({pc, irq_ack}), 64'({16'h0004, NSRC'(1) << 2}));
    repeat (2) cycle(0, 0, 0, 16'h0, 0, '0);
    cycle(1, 0, 0, 16'h0, 1, '0);
    repeat (3) cycle(0, 0, 0, 16'h0, 0, '0);
    check("R11 return after src3", 64'(pc), 64'h1243);
    cycle(1, 0, 0, 16'h0, 0, '0);
    check("R5 src20 slot", 64'({pc, irq_ack}), 64'({16'h0026, NSRC'(1) << 19}));

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] rq;
      rq = '0;
      if ($urandom % 6 == 0) rq[$urandom % NSRC] = 1'b1;
      if ($urandom % 20 == 0) rq[$urandom % NSRC] = 1'b1;
      cycle(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 5) == 0,
            16'($urandom), ($urandom % 12) == 0, rq);
    end
    lockstep_check();
    report();
    $finish;
  end

endmodule